// File: doc/BRIEF.md
# Receive Length Field Checker

This block watches the byte stream of received Ethernet frames, one byte per cycle, with a marker on the first and on the last byte of each frame. From the two bytes that follow the addresses (frame bytes 13 and 14, counting from 1) it takes the length/type value. At the last byte it compares the number of payload bytes that actually arrived with the length that value claims. A frame whose payload is short is counted in an 8-bit statistics register, which sits on a 32-bit register bus. Values of 0x0600 and above are type identifiers, not lengths, and are never counted. Oversized frames are not counted either. A configuration enable turns the check on and off.

Frame tracking is done by a four-state machine:
- `ST_IDLE`: waiting for a start marker.
- `ST_HDR`: bytes 1 to 14, during which the field is captured.
- `ST_BODY`: payload and FCS bytes.
- `ST_LONG`: the frame has passed the size limit.

The transitions are:
- IDLE→HDR: a valid start byte that is not also an end byte.
- HDR→BODY: byte 14 arrives without an end marker.
- HDR→IDLE: an end marker on byte 14 or earlier.
- BODY→LONG: byte 1518 arrives without an end marker.
- BODY→IDLE and LONG→IDLE: an end marker.
- Any state→HDR: a new start marker, which abandons the frame in progress.
- Any state→IDLE: a single-byte frame, where the start and end markers fall on the same byte.

Top module: `rx_lenchk`

## Requirements
- R1: After reset the count is 0 and `reg_rdata` reads 0x00000000.
- R2: The length field is byte 13 (most significant) followed by byte 14. A frame of N total bytes is counted when the field is below 0x0600 and N − 18 (the payload, without the 14 header bytes and the 4 FCS bytes) is less than the field. The count then increases by one on the clock edge that samples the end byte. This includes 14- to 17-byte frames.
- R3: A frame whose payload equals or exceeds the field value is not counted.
- R4: A field value of 0x0600 or more is a type identifier, and the frame is not counted.
- R5: A frame longer than 1518 bytes is not counted, whatever its field says.
- R6: A frame is not counted when `chk_en` is low on its end byte.
- R7: A frame that ends before byte 14, including a single-byte frame, is not counted.
- R8: The count saturates at 255.
- R9: A write with `reg_wr` high loads `reg_wdata[7:0]` into the count on that clock edge. If a counted frame ends on the same edge, the write wins.
- R10: `reg_rdata[7:0]` shows the count, and `reg_rdata[31:8]` always reads zero.
- R11: A start marker inside a frame abandons that frame uncounted and begins a new one at byte 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| chk_en | input | 1 | Length check enable |
| reg_wr | input | 1 | Write strobe for the statistics register |
| reg_wdata | input | 32 | Write data; bits 7:0 are used |
| reg_rdata | output | 32 | Statistics register read value |

## Verification
A wrong internal state shows up at `reg_rdata` at the latest on the clock edge that samples the end byte of the frame concerned. Some faults leave the count one off at that point: a byte position that is off by one, a field byte captured from the wrong position, or a missed transition into `ST_LONG`. The stimulus table therefore places frames on each side of every boundary: payload equal to the field, field 0x05FF against 0x0600, and 1518 against 1519 bytes. Faults in the saturation logic and in the write priority appear in the cycle right after the edge on which they act.

// File: rtl/lenchk_pkg.sv
package lenchk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_LONG
    } frm_state_e;
endpackage

// File: rtl/lenchk_frame.sv
module lenchk_frame
    import lenchk_pkg::*;
#(
    parameter int MAX_LEN  = 1518,
    parameter int HDR_LEN  = 14,
    parameter int FCS_LEN  = 4,
    parameter int TYPE_MIN = 16'h0600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic [7:0] rx_data,
    input  logic       chk_en,
    output logic       short_hit
);
    localparam int POS_W = $clog2(MAX_LEN + 1);
    localparam int CMP_W = 17;

    frm_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_now;
    logic [15:0]      field_q, field_now;
    logic             at_hi, at_lo, decide;

    // position of the byte on the bus, counting from 1
    assign pos_now = rx_sof ? POS_W'(1) : pos_q + POS_W'(1);
    assign at_hi   = (rx_sof || state_q == ST_HDR) && pos_now == POS_W'(HDR_LEN - 1);
    assign at_lo   = (state_q == ST_HDR) && !rx_sof && pos_now == POS_W'(HDR_LEN);
    assign field_now = at_lo ? {field_q[15:8], rx_data} : field_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rx_valid) begin
            if (rx_sof) begin
                state_d = rx_eof ? ST_IDLE : ST_HDR;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_HDR: begin
                        if (rx_eof)
                            state_d = ST_IDLE;
                        else if (pos_now == POS_W'(HDR_LEN))
                            state_d = ST_BODY;
                    end
                    ST_BODY: begin
                        if (rx_eof)
                            state_d = ST_IDLE;
                        else if (pos_now >= POS_W'(MAX_LEN))
                            state_d = ST_LONG;
                    end
                    ST_LONG: if (rx_eof) state_d = ST_IDLE;
                endcase
            end
        end
    end

    // state register and byte tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            field_q <= '0;
        end else begin
            state_q <= state_d;
            if (rx_valid && (rx_sof || state_q != ST_LONG))
                pos_q <= pos_now;
            if (rx_valid && at_hi)
                field_q[15:8] <= rx_data;
            if (rx_valid && at_lo)
                field_q[7:0] <= rx_data;
        end
    end

    // output logic: classify the frame on its end byte
    always_comb begin
        decide = 1'b0;
        if (rx_valid && rx_eof && !rx_sof) begin
            unique case (state_q)
                ST_HDR:  decide = (pos_now == POS_W'(HDR_LEN));
                ST_BODY: decide = 1'b1;
                ST_IDLE, ST_LONG: decide = 1'b0;
            endcase
        end
        short_hit = decide && chk_en
                 && (field_now < 16'(TYPE_MIN))
                 && (CMP_W'(pos_now) < CMP_W'(field_now) + CMP_W'(HDR_LEN + FCS_LEN));
    end

    p_long_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LONG && rx_valid && !rx_eof && !rx_sof) |=> state_q == ST_LONG);
    p_long_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LONG) |-> !short_hit);
    p_hdr_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && pos_now < POS_W'(HDR_LEN)) |-> !short_hit);
    p_idle_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rx_sof) |-> !short_hit);
endmodule

// File: rtl/lenchk_stat.sv
module lenchk_stat #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr)
            cnt_q <= wdata;
        else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt = cnt_q;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !wr) |=> cnt_q == CNT_MAX);
    p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt_q == $past(wdata));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_lenchk.sv
module rx_lenchk #(
    parameter int MAX_LEN  = 1518,
    parameter int HDR_LEN  = 14,
    parameter int FCS_LEN  = 4,
    parameter int TYPE_MIN = 16'h0600,
    parameter int CNT_W    = 8,
    parameter int BUS_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             chk_en,
    input  logic             reg_wr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata
);
    logic             hit;
    logic [CNT_W-1:0] cnt;

    lenchk_frame #(
        .MAX_LEN(MAX_LEN), .HDR_LEN(HDR_LEN),
        .FCS_LEN(FCS_LEN), .TYPE_MIN(TYPE_MIN)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .chk_en(chk_en), .short_hit(hit)
    );

    lenchk_stat #(.CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .inc(hit), .wr(reg_wr),
        .wdata(reg_wdata[CNT_W-1:0]), .cnt(cnt)
    );

    assign reg_rdata = {{(BUS_W-CNT_W){1'b0}}, cnt};

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr) |-> reg_rdata[BUS_W-1:CNT_W] == '0);
endmodule

// File: tb/tb_rx_lenchk.sv
`timescale 1ns/1ps
module tb_rx_lenchk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        chk_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_lenchk dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .chk_en(chk_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [15:0] n;
        logic [15:0] f;
        logic        en;
        logic        inc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{16'd64,   16'd100,    1'b1, 1'b1},  // R2 short payload
        '{16'd64,   16'd46,     1'b1, 1'b0},  // R3 equal
        '{16'd64,   16'd45,     1'b1, 1'b0},  // R3 longer
        '{16'd64,   16'd47,     1'b1, 1'b1},  // R2 one short
        '{16'd64,   16'h0600,   1'b1, 1'b0},  // R4 type boundary
        '{16'd64,   16'h05FF,   1'b1, 1'b1},  // R4 largest length
        '{16'd64,   16'h0800,   1'b1, 1'b0},  // R4 type
        '{16'd1518, 16'd1535,   1'b1, 1'b1},  // R5 at limit
        '{16'd1519, 16'd1535,   1'b1, 1'b0},  // R5 over limit
        '{16'd2000, 16'd1535,   1'b1, 1'b0},  // R5 far over
        '{16'd64,   16'd100,    1'b0, 1'b0},  // R6 disabled
        '{16'd13,   16'h0010,   1'b1, 1'b0},  // R7 before byte 14
        '{16'd14,   16'h0010,   1'b1, 1'b1},  // R2 ends at byte 14
        '{16'd1,    16'h0010,   1'b1, 1'b0}   // R7 single byte
    };

    task automatic check(string req, logic [31:0] exp);
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg_rdata=%08h expected=%08h", req, reg_rdata, exp);
        end
    endtask

    // drives n bytes; leaves the bus idle at the negedge after the end byte
    task automatic send(int n, logic [15:0] f, logic en, bit wr_eof, logic [31:0] wd,
                        bit do_eof);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 1);
            rx_eof   = do_eof && (i == n);
            rx_data  = (i == 13) ? f[15:8] : (i == 14) ? f[7:0] : 8'(i);
            chk_en   = en;
            reg_wr   = wr_eof && (i == n);
            reg_wdata = wd;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic write_reg(logic [31:0] wd);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = wd;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'h0);

        for (int k = 0; k < NV; k++) begin
            send(int'(VEC[k].n), VEC[k].f, VEC[k].en, 1'b0, 32'h0, 1'b1);
            if (VEC[k].inc) exp_cnt++;
            check($sformatf("R2-table[%0d]", k), 32'(exp_cnt));
        end

        // R11: abandoned frame with a length field, then restart
        send(30, 16'd500, 1'b1, 1'b0, 32'h0, 1'b0);
        send(64, 16'd10, 1'b1, 1'b0, 32'h0, 1'b1);
        check("R11", 32'(exp_cnt));
        send(30, 16'h0800, 1'b1, 1'b0, 32'h0, 1'b0);
        send(64, 16'd100, 1'b1, 1'b0, 32'h0, 1'b1);
        exp_cnt++;
        check("R11", 32'(exp_cnt));

        // R9 write then R8 saturation
        write_reg(32'h0000_00FE);
        check("R9", 32'h0000_00FE);
        send(64, 16'd100, 1'b1, 1'b0, 32'h0, 1'b1);
        check("R8", 32'h0000_00FF);
        send(64, 16'd100, 1'b1, 1'b0, 32'h0, 1'b1);
        check("R8", 32'h0000_00FF);

        // R9 write wins over increment on the same edge
        send(64, 16'd100, 1'b1, 1'b1, 32'h0000_0010, 1'b1);
        check("R9", 32'h0000_0010);

        // R10 upper bits read zero
        write_reg(32'hFFFF_FF5A);
        check("R10", 32'h0000_005A);

        // R1 reset clears the count
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: timeout actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule